// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block connects a synchronous request port to an external asynchronous static RAM of 2^18 bytes. A client offers one read or one write at a time on a valid/ready handshake. The controller turns each request into a memory access on the RAM pins and holds every phase for a whole number of clock cycles. Each count is the required nanosecond figure divided by the clock period and rounded up, with a floor of one cycle. Reads return their byte on the request side together with a single-cycle valid pulse.

The RAM is selected only when both of its enables are active: the low-true enable is low and the high-true enable is high. Between accesses the controller drops both enables, so the part rests in its low-power deselected state. The controller drives the shared 8-bit data bus only while write enable is low. After a read it waits out the RAM's output float time before it accepts the next request.

Two timing sets are built in: a 55 ns grade (`SPEED_GRADE` 0) and a 70 ns grade (`SPEED_GRADE` 1). With the defaults (8 ns clock, 55 ns grade) the phase lengths are:
- read access: 7 cycles
- write-enable-low window: 6 cycles
- minimum spacing between access starts: 7 cycles
- read float allowance: 4 cycles

Top module: `sram_ctl`

## Requirements
- R1: While reset is high and in the first cycle after it, `req_ready`=1, `mem_ce_n`=1, `mem_ce`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0 and `rsp_valid`=0.
- R2: `mem_ce` is always the inverse of `mem_ce_n`. Both enables are inactive whenever no access is in progress.
- R3: A read accepted at edge s selects the RAM with `mem_oe_n`=0 and `mem_we_n`=1 for exactly 7 cycles (from after edge s until edge s+7). At edge s+7 the enables and output enable are released.
- R4: The read byte is the value of `mem_dq_in` sampled at edge s+7. It appears on `rsp_rdata` with `rsp_valid`=1 for exactly the one cycle after edge s+7.
- R5: A write accepted at edge s selects the RAM with `mem_we_n`=1 for one setup cycle. It then holds `mem_we_n`=0 for 6 cycles. At edge s+7 write enable, both chip enables and the bus drive are released together.
- R6: `mem_dq_oe` is 1 exactly while `mem_we_n` is 0, never while `mem_oe_n` is 0. `mem_dq_out` carries the request's write data and is stable throughout the drive.
- R7: `mem_addr` takes the request address at the accepting edge. It is stable for as long as the RAM stays selected.
- R8: `req_ready` falls at the accepting edge. After a write it returns high 8 cycles after the accepting edge. Two accepts are never closer than 7 cycles.
- R9: After a read, `req_ready` returns high 11 cycles after the accepting edge, that is 4 cycles after output enable is released. A following write therefore cannot drive the bus inside the RAM's float time.
- R10: `req_valid` while `req_ready` is 0 starts nothing. Address, enables and strobes keep following the access already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data valid pulse |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 18 | RAM address pins |
| mem_ce_n | output | 1 | RAM enable, active low |
| mem_ce | output | 1 | RAM enable, active high |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 8 | Data read from the RAM bus |

## Verification
The bench holds `req_valid` high with a new address while an access is still running. A controller that ignored `req_ready` would move `mem_addr` in mid-access and corrupt a write. A read of an address just written checks the write window: if write enable or drive were released early, the wrong byte would be stored and read back. A write right after a read targets the float interval; a controller that returned ready too soon would show `req_ready` high before cycle 11 and drive into the RAM's output. Accesses at address 0, the top address and a never-written location cover the extremes and catch a capture taken a cycle early or late.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_RD_WAIT,
    ST_GAP
  } ctl_state_t;

  // nanosecond figures of one speed grade
  typedef struct packed {
    int cyc_ns;   // minimum spacing of access starts
    int wp_ns;    // write enable low width
    int aw_ns;    // address valid to end of write
    int dw_ns;    // data valid before end of write
    int aa_ns;    // address to read data valid
    int ohz_ns;   // output float after output enable off
  } speed_set_t;

  function automatic speed_set_t speed_of(input int grade);
    speed_set_t s;
    if (grade == 1) s = '{cyc_ns: 70, wp_ns: 35, aw_ns: 70, dw_ns: 30, aa_ns: 70, ohz_ns: 30};
    else            s = '{cyc_ns: 55, wp_ns: 30, aw_ns: 55, dw_ns: 25, aa_ns: 55, ohz_ns: 25};
    return s;
  endfunction

  function automatic int ns_to_cycles(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sram_span_counter.sv
module sram_span_counter #(
  parameter int LIMIT = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic reached
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= W'(LIMIT);
    else if (restart)          cnt <= W'(1);
    else if (cnt < W'(LIMIT))  cnt <= cnt + 1'b1;
  end

  assign reached = (cnt >= W'(LIMIT));
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 8,
  parameter int SPEED_GRADE   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam speed_set_t SPD = speed_of(SPEED_GRADE);
  localparam int N_CYC  = ns_to_cycles(SPD.cyc_ns, CLK_PERIOD_NS);
  localparam int N_AA   = ns_to_cycles(SPD.aa_ns, CLK_PERIOD_NS);
  localparam int N_OHZ  = ns_to_cycles(SPD.ohz_ns, CLK_PERIOD_NS);
  // one setup cycle precedes the low window, so the address term loses one
  localparam int N_WP   = max2(max2(ns_to_cycles(SPD.wp_ns, CLK_PERIOD_NS),
                                    ns_to_cycles(SPD.dw_ns, CLK_PERIOD_NS)),
                               max2(ns_to_cycles(SPD.aw_ns, CLK_PERIOD_NS) - 1, 1));
  localparam int N_TMAX = max2(max2(N_AA, N_WP), N_OHZ);
  localparam int TMR_W  = $clog2(N_TMAX + 1);

  ctl_state_t       state;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             span_met;
  logic             accept;

  assign accept = (state == ST_IDLE) && req_valid;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE:     if (req_valid) begin tmr_load = 1'b1; tmr_val = TMR_W'(N_AA - 1); end
      ST_WR_SETUP: begin tmr_load = 1'b1; tmr_val = TMR_W'(N_WP - 1); end
      ST_WR_PULSE: if (tmr_zero) begin tmr_load = 1'b1; tmr_val = '0; end
      ST_RD_WAIT:  if (tmr_zero) begin tmr_load = 1'b1; tmr_val = TMR_W'(N_OHZ - 1); end
      default:     ;
    endcase
  end

  sram_phase_timer #(.W(TMR_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram_span_counter #(.LIMIT(N_CYC)) u_span (
    .clk     (clk),
    .rst     (rst),
    .restart (accept),
    .reached (span_met)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      req_ready  <= 1'b1;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      mem_addr   <= '0;
      mem_ce_n   <= 1'b1;
      mem_ce     <= 1'b0;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            req_ready <= 1'b0;
            mem_addr  <= req_addr;
            mem_ce_n  <= 1'b0;
            mem_ce    <= 1'b1;
            if (req_write) begin
              mem_dq_out <= req_wdata;
              state      <= ST_WR_SETUP;
            end else begin
              mem_oe_n <= 1'b0;
              state    <= ST_RD_WAIT;
            end
          end
        end
        ST_WR_SETUP: begin
          mem_we_n  <= 1'b0;
          mem_dq_oe <= 1'b1;
          state     <= ST_WR_PULSE;
        end
        ST_WR_PULSE: begin
          if (tmr_zero) begin
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            mem_ce_n  <= 1'b1;
            mem_ce    <= 1'b0;
            state     <= ST_GAP;
          end
        end
        ST_RD_WAIT: begin
          if (tmr_zero) begin
            rsp_rdata <= mem_dq_in;
            rsp_valid <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_ce_n  <= 1'b1;
            mem_ce    <= 1'b0;
            state     <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tmr_zero && span_met) begin
            req_ready <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_ctl_checker.sv
module sram_ctl_checker #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_ce,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  p_ce_pair_r2: assert property (@(posedge clk) disable iff (rst)
    mem_ce_n == !mem_ce);

  p_idle_deselect_r2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> mem_ce_n);

  p_read_strobes_r3: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n));

  p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_rsp_released_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (mem_ce_n && mem_oe_n));

  p_drive_in_write_r6: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_we_n && !mem_ce_n && mem_oe_n));

  p_we_with_drive_r5: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_dq_oe);

  p_wdata_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

  p_addr_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  p_accept_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && !mem_ce_n));
endmodule

bind sram_ctl sram_ctl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_ce     (mem_ce),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_ctl_tb.sv
`timescale 1ns/1ps
module sram_ctl_tb;
  // phase lengths taken from the requirements (8 ns clock, 55 ns grade)
  localparam int T_RD   = 7;   // R3
  localparam int T_WLOW = 6;   // R5
  localparam int RDY_WR = 8;   // R8
  localparam int RDY_RD = 11;  // R9

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [17:0] req_addr  = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [17:0] mem_addr;
  logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  always #4 clk = ~clk;

  sram_ctl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  function automatic void chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endfunction

  // behavioural RAM on the pins
  logic [7:0] smem [int];
  logic [7:0] sram_q = 8'h00;
  logic       wr_open = 1'b0;
  logic [17:0] wr_a;
  logic [7:0]  wr_d;
  assign mem_dq_in = sram_q;

  always @(negedge clk) begin
    logic sel;
    sel = !mem_ce_n && mem_ce;
    if (wr_open && (mem_we_n || !sel)) smem[int'(wr_a)] = wr_d;
    wr_open = sel && !mem_we_n;
    if (wr_open) begin wr_a = mem_addr; wr_d = mem_dq_oe ? mem_dq_out : 8'hXX; end
    if (sel && !mem_oe_n && mem_we_n)
      sram_q <= smem.exists(int'(mem_addr)) ? smem[int'(mem_addr)] : 8'hEE;
    else
      sram_q <= 8'h00;
  end

  // cycle reference model
  logic [7:0] shadow [int];
  logic        m_active = 1'b0;
  int          m_k = 0;
  logic        m_wr = 1'b0;
  logic [17:0] m_addr = '0;
  logic [7:0]  m_data = '0;
  logic        m_ready;
  assign m_ready = !m_active || (m_k >= (m_wr ? RDY_WR : RDY_RD));

  always @(posedge clk) begin
    if (rst) begin
      m_active <= 1'b0;
      m_k      <= 0;
    end else if (m_ready && req_valid) begin
      m_active <= 1'b1;
      m_k      <= 0;
      m_wr     <= req_write;
      m_addr   <= req_addr;
      if (req_write) begin
        m_data <= req_wdata;
        shadow[int'(req_addr)] = req_wdata;
      end else begin
        m_data <= shadow.exists(int'(req_addr)) ? shadow[int'(req_addr)] : 8'hEE;
      end
    end else if (m_active && m_k < 1000) begin
      m_k <= m_k + 1;
    end
  end

  always @(negedge clk) begin
    logic e_sel, e_oe_n, e_we_n, e_dqoe, e_rv;
    if (!rst && !done) begin
      e_sel = 0; e_oe_n = 1; e_we_n = 1; e_dqoe = 0; e_rv = 0;
      if (m_active && !m_wr) begin
        e_sel  = (m_k < T_RD);
        e_oe_n = !(m_k < T_RD);
        e_rv   = (m_k == T_RD);
      end else if (m_active) begin
        e_sel  = (m_k <= T_WLOW);
        e_we_n = !(m_k >= 1 && m_k <= T_WLOW);
        e_dqoe = !e_we_n;
      end
      chk(m_wr ? "R8 req_ready" : "R9 req_ready", req_ready, m_ready);
      chk("R2 mem_ce_n", mem_ce_n, !e_sel);
      chk("R2 mem_ce", mem_ce, e_sel);
      chk("R3 mem_oe_n", mem_oe_n, e_oe_n);
      chk("R5 mem_we_n", mem_we_n, e_we_n);
      chk("R6 mem_dq_oe", mem_dq_oe, e_dqoe);
      chk("R4 rsp_valid", rsp_valid, e_rv);
      if (e_sel) chk((req_valid && !m_ready) ? "R10 mem_addr" : "R7 mem_addr", mem_addr, m_addr);
      if (e_dqoe) chk("R6 mem_dq_out", mem_dq_out, m_data);
      if (e_rv) chk("R4 rsp_rdata", rsp_rdata, m_data);
    end
  end

  task automatic issue(input logic w, input logic [17:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 req_ready", req_ready, 1);
    chk("R1 mem_ce_n", mem_ce_n, 1);
    chk("R1 mem_ce", mem_ce, 0);
    chk("R1 mem_we_n", mem_we_n, 1);
    chk("R1 mem_oe_n", mem_oe_n, 1);
    chk("R1 mem_dq_oe", mem_dq_oe, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    issue(1, 18'h00000, 8'h5A);
    issue(1, 18'h3FFFF, 8'hA5);
    issue(1, 18'h12345, 8'hFF);
    issue(1, 18'h00001, 8'h00);
    issue(0, 18'h00000, 8'h00);
    issue(0, 18'h3FFFF, 8'h00);
    issue(0, 18'h12345, 8'h00);
    issue(0, 18'h00001, 8'h00);
    issue(0, 18'h2AAAA, 8'h00);           // never written
    issue(1, 18'h0F0F0, 8'hC3);           // R10: next request waits with valid high
    issue(0, 18'h0F0F0, 8'h00);
    issue(1, 18'h00000, 8'h3C);           // R9: write right after read
    issue(0, 18'h00000, 8'h00);
    repeat (3) @(negedge clk);
    issue(0, 18'h3FFFF, 8'h00);
    repeat (16) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      finish_run();
    end
  end
endmodule